// File: doc/BRIEF.md
# Display power-up sequencer

This block brings an LCD panel out of reset and programs it, without help from software. A single start pulse first drives the panel reset line through a fixed high, low, high pattern. After a settling wait, the block asks the serial engine to read the panel identity byte. That byte picks one of two built-in initialisation tables. Each table entry is a command byte, zero or more parameter bytes and a post-entry wait in milliseconds. The block streams the entries in order and holds each wait. It closes with a display-on command, a fixed wait and a sleep-out command.

All timing is counted in pulses of a one-millisecond strobe input. Each word goes to an external serial engine over a request/done handshake. Status is reported on three lines: busy while the sequence runs, a sticky done flag, and a sticky error flag.

Top module: `lcd_bringup_seq`

## Requirements
- R1: While `rstN` is low and afterwards until a start, `busy`, `done`, `errFlag`, `panelRst` and `xferReq` are all 0.
- R2: On start, `panelRst` goes high for RST_HI_MS tick pulses (default 100), then low for RST_LO_MS pulses (default 40), then high again. No request is raised until RST_WAIT_MS further pulses (default 100) have passed.
- R3: The first transfer after the reset pattern is the identity read (`xferRead` = 1). No other transfer is a read.
- R4: An identity byte of 0x80 selects table A, and any other value selects table B. Entries are sent strictly in table order. Table A is: 0x36 {0x08} wait 0; 0x3A {0x66} wait 0; 0xE1 {0x1F,0x20} wait 20; 0xB4 {0x02} wait 100. Table B is: 0xBA {0x60} wait 0; 0x13 {} wait 0; 0xB1 {0x00,0x13,0x13} wait 3.
- R5: `xferWord` bit 8 is 0 for a command byte and 1 for a parameter byte. Bits 7:0 carry the byte.
- R6: After the last word of an entry, the next command is requested once exactly the entry's wait in tick pulses has passed. A wait of zero leaves the request low for exactly one cycle.
- R7: After the table, command 0x29 is sent with no parameters, then DISP_WAIT_MS pulses (default 100) pass, then command 0x11 is sent with no parameters.
- R8: `busy` rises in the cycle after start and stays high until the 0x11 transfer completes. `done` then stays high until the next accepted start, and `done` and `busy` are never high together.
- R9: If the identity read ends with `xferErr`, the block returns to idle without any further transfer, with `errFlag` = 1 and `done` = 0.
- R10: A table or closing write that ends with `xferErr` sets `errFlag`, and the sequence goes on unchanged. `errFlag` holds until the next accepted start clears it.
- R11: A start pulse while `busy` is high is ignored.
- R12: Once raised, `xferReq` stays high with `xferWord` and `xferRead` stable until a cycle with `xferDone`. Words inside one entry follow back to back, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle strobe every millisecond |
| start | input | 1 | Start pulse, accepted only when idle |
| xferReq | output | 1 | Word request to the serial engine |
| xferRead | output | 1 | Current request is the identity read |
| xferWord | output | 9 | Word to send: bit 8 is the data flag, bits 7:0 are the byte |
| xferDone | input | 1 | One-cycle completion of the current word |
| xferErr | input | 1 | Completion carried an error, valid with xferDone |
| rdData | input | 8 | Identity byte, valid with a read's xferDone |
| panelRst | output | 1 | Panel reset line level |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed |
| errFlag | output | 1 | Sticky error since the last start |

## Verification
The sequence is run with several identity values: 0x80, 0x81 and 0x00. These show that only the exact value selects table A and that near misses fall to table B. A write error injected mid-table shows the stream is unchanged while the flag sticks. An identity-read error shows the abort path. A second start during the reset pattern shows the request is ignored, because the pulse lengths and word stream stay as they would otherwise be. Gaps between words are measured both in tick pulses and in idle cycles. This separates back-to-back parameters, zero waits and real waits.

// File: rtl/lcd_bringup_pkg.sv
package lcd_bringup_pkg;

  localparam int ENT_IDX_W  = 3;
  localparam int PAR_IDX_W  = 4;
  localparam int PAR_ADDR_W = 5;
  localparam int TBL_A_LEN  = 4;
  localparam int TBL_B_LEN  = 3;

  localparam logic [7:0] CMD_DISP_ON   = 8'h29;
  localparam logic [7:0] CMD_SLEEP_OUT = 8'h11;

  typedef struct packed {
    logic [7:0]            cmd;
    logic [PAR_IDX_W-1:0]  nPar;
    logic [PAR_ADDR_W-1:0] parBase;
    logic [7:0]            dlyMs;
  } entry_t;

  typedef enum logic [2:0] {
    DLY_RST_HI, DLY_RST_LO, DLY_RST_WAIT, DLY_ENTRY, DLY_DISP
  } dlySel_t;

  typedef enum logic [1:0] {
    W_CMD, W_PAR, W_DISPON, W_SLPOUT
  } wordSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     ldDly;
    dlySel_t  dlySel;
    logic     capId;
    logic     clrIdx;
    logic     nextEntry;
    logic     nextParam;
    wordSel_t wordSel;
  } dpCmd_t;

  // entry table: table B entries sit behind table A, selected by tblB
  function automatic entry_t entryRom(input logic tblB, input logic [ENT_IDX_W-1:0] idx);
    entry_t e;
    e = '0;
    case ({tblB, idx})
      4'b0_000: e = '{cmd: 8'h36, nPar: 4'd1, parBase: 5'd0, dlyMs: 8'd0};
      4'b0_001: e = '{cmd: 8'h3A, nPar: 4'd1, parBase: 5'd1, dlyMs: 8'd0};
      4'b0_010: e = '{cmd: 8'hE1, nPar: 4'd2, parBase: 5'd2, dlyMs: 8'd20};
      4'b0_011: e = '{cmd: 8'hB4, nPar: 4'd1, parBase: 5'd4, dlyMs: 8'd100};
      4'b1_000: e = '{cmd: 8'hBA, nPar: 4'd1, parBase: 5'd5, dlyMs: 8'd0};
      4'b1_001: e = '{cmd: 8'h13, nPar: 4'd0, parBase: 5'd5, dlyMs: 8'd0};
      4'b1_010: e = '{cmd: 8'hB1, nPar: 4'd3, parBase: 5'd6, dlyMs: 8'd3};
      default:  e = '0;
    endcase
    return e;
  endfunction

  function automatic logic [7:0] parRom(input logic [PAR_ADDR_W-1:0] a);
    logic [7:0] b;
    case (a)
      5'd0:    b = 8'h08;
      5'd1:    b = 8'h66;
      5'd2:    b = 8'h1F;
      5'd3:    b = 8'h20;
      5'd4:    b = 8'h02;
      5'd5:    b = 8'h60;
      5'd6:    b = 8'h00;
      5'd7:    b = 8'h13;
      5'd8:    b = 8'h13;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/lcd_bringup_dp.sv
module lcd_bringup_dp
  import lcd_bringup_pkg::*;
#(
  parameter int         DLY_W        = 16,
  parameter int         RST_HI_MS    = 100,
  parameter int         RST_LO_MS    = 40,
  parameter int         RST_WAIT_MS  = 100,
  parameter int         DISP_WAIT_MS = 100,
  parameter logic [7:0] ID_MATCH     = 8'h80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  dpCmd_t     cmd,
  input  logic [7:0] rdData,
  output logic       dlyZero,
  output logic       lastEntry,
  output logic       lastParam,
  output logic       hasParams,
  output logic [8:0] xferWord
);

  logic [DLY_W-1:0]     dlyCnt;
  logic [DLY_W-1:0]     dlyLoad;
  logic [ENT_IDX_W-1:0] entIdx;
  logic [PAR_IDX_W-1:0] parIdx;
  logic                 tblB;
  entry_t               ent;

  assign ent = entryRom(tblB, entIdx);

  always_comb begin
    case (cmd.dlySel)
      DLY_RST_HI:   dlyLoad = DLY_W'(RST_HI_MS);
      DLY_RST_LO:   dlyLoad = DLY_W'(RST_LO_MS);
      DLY_RST_WAIT: dlyLoad = DLY_W'(RST_WAIT_MS);
      DLY_ENTRY:    dlyLoad = DLY_W'(ent.dlyMs);
      DLY_DISP:     dlyLoad = DLY_W'(DISP_WAIT_MS);
      default:      dlyLoad = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= '0;
      entIdx <= '0;
      parIdx <= '0;
      tblB   <= 1'b0;
    end else begin
      if (cmd.ldDly)
        dlyCnt <= dlyLoad;
      else if (msTick && dlyCnt != '0)
        dlyCnt <= dlyCnt - 1'b1;

      if (cmd.capId)
        tblB <= (rdData != ID_MATCH);

      if (cmd.clrIdx) begin
        entIdx <= '0;
        parIdx <= '0;
      end else if (cmd.nextEntry) begin
        entIdx <= entIdx + 1'b1;
        parIdx <= '0;
      end else if (cmd.nextParam) begin
        parIdx <= parIdx + 1'b1;
      end
    end
  end

  assign dlyZero   = (dlyCnt == '0);
  assign hasParams = (ent.nPar != '0);
  assign lastParam = ((parIdx + PAR_IDX_W'(1)) == ent.nPar);
  assign lastEntry = (entIdx == (tblB ? ENT_IDX_W'(TBL_B_LEN - 1) : ENT_IDX_W'(TBL_A_LEN - 1)));

  always_comb begin
    case (cmd.wordSel)
      W_CMD:    xferWord = {1'b0, ent.cmd};
      W_PAR:    xferWord = {1'b1, parRom(PAR_ADDR_W'(ent.parBase + PAR_ADDR_W'(parIdx)))};
      W_DISPON: xferWord = {1'b0, CMD_DISP_ON};
      default:  xferWord = {1'b0, CMD_SLEEP_OUT};
    endcase
  end

endmodule

// File: rtl/lcd_bringup_ctrl.sv
module lcd_bringup_ctrl
  import lcd_bringup_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   xferDone,
  input  logic   xferErr,
  input  logic   dlyZero,
  input  logic   lastEntry,
  input  logic   lastParam,
  input  logic   hasParams,
  output dpCmd_t cmd,
  output logic   xferReq,
  output logic   xferRead,
  output logic   panelRst,
  output logic   busy,
  output logic   done,
  output logic   errFlag
);

  typedef enum logic [3:0] {
    S_IDLE, S_RHI, S_RLO, S_RWAIT, S_IDRD,
    S_CMD, S_PAR, S_EDLY, S_DON, S_DWAIT, S_SLP
  } state_t;

  state_t state, nxt;
  logic   rstLine, doneR, errR;

  always_comb begin
    nxt = state;
    cmd = '0;
    case (state)
      S_IDLE: if (start) begin
        nxt = S_RHI;  cmd.ldDly = 1'b1; cmd.dlySel = DLY_RST_HI;
      end
      S_RHI: if (dlyZero) begin
        nxt = S_RLO;  cmd.ldDly = 1'b1; cmd.dlySel = DLY_RST_LO;
      end
      S_RLO: if (dlyZero) begin
        nxt = S_RWAIT; cmd.ldDly = 1'b1; cmd.dlySel = DLY_RST_WAIT;
      end
      S_RWAIT: if (dlyZero) nxt = S_IDRD;
      S_IDRD: if (xferDone) begin
        if (xferErr) nxt = S_IDLE;
        else begin
          nxt = S_CMD; cmd.capId = 1'b1; cmd.clrIdx = 1'b1;
        end
      end
      S_CMD: begin
        cmd.wordSel = W_CMD;
        if (xferDone) begin
          if (hasParams) nxt = S_PAR;
          else begin
            nxt = S_EDLY; cmd.ldDly = 1'b1; cmd.dlySel = DLY_ENTRY;
          end
        end
      end
      S_PAR: begin
        cmd.wordSel = W_PAR;
        if (xferDone) begin
          if (lastParam) begin
            nxt = S_EDLY; cmd.ldDly = 1'b1; cmd.dlySel = DLY_ENTRY;
          end else cmd.nextParam = 1'b1;
        end
      end
      S_EDLY: if (dlyZero) begin
        if (lastEntry) nxt = S_DON;
        else begin
          nxt = S_CMD; cmd.nextEntry = 1'b1;
        end
      end
      S_DON: begin
        cmd.wordSel = W_DISPON;
        if (xferDone) begin
          nxt = S_DWAIT; cmd.ldDly = 1'b1; cmd.dlySel = DLY_DISP;
        end
      end
      S_DWAIT: if (dlyZero) nxt = S_SLP;
      S_SLP: begin
        cmd.wordSel = W_SLPOUT;
        if (xferDone) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign xferReq  = (state == S_IDRD) || (state == S_CMD) || (state == S_PAR) ||
                    (state == S_DON)  || (state == S_SLP);
  assign xferRead = (state == S_IDRD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      rstLine <= 1'b0;
      doneR   <= 1'b0;
      errR    <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && start)      rstLine <= 1'b1;
      else if (state == S_RHI && dlyZero) rstLine <= 1'b0;
      else if (state == S_RLO && dlyZero) rstLine <= 1'b1;

      if (state == S_IDLE && start)        doneR <= 1'b0;
      else if (state == S_SLP && xferDone) doneR <= 1'b1;

      if (state == S_IDLE && start)               errR <= 1'b0;
      else if (xferReq && xferDone && xferErr)    errR <= 1'b1;
    end
  end

  assign panelRst = rstLine;
  assign busy     = (state != S_IDLE);
  assign done     = doneR;
  assign errFlag  = errR;

  // R2: no serial traffic while the reset line is low
  a_r2_quiet_reset: assert property (@(posedge clk) disable iff (!rstN)
    !panelRst |-> !xferReq);

  // R8: busy and done exclusive, done sticky until start
  a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);

  // R10: error flag sticky until start
  a_r10_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !start |=> errFlag);

  // R9: failed identity read aborts to idle
  a_r9_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDRD && xferDone && xferErr) |=> (!busy && errFlag && !done));

  // R6: an expired wait leaves the wait state on the next edge
  a_r6_wait_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EDLY && dlyZero) |=> (state != S_EDLY));

endmodule

// File: rtl/lcd_bringup_seq.sv
module lcd_bringup_seq
  import lcd_bringup_pkg::*;
#(
  parameter int         DLY_W        = 16,
  parameter int         RST_HI_MS    = 100,
  parameter int         RST_LO_MS    = 40,
  parameter int         RST_WAIT_MS  = 100,
  parameter int         DISP_WAIT_MS = 100,
  parameter logic [7:0] ID_MATCH     = 8'h80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       start,
  output logic       xferReq,
  output logic       xferRead,
  output logic [8:0] xferWord,
  input  logic       xferDone,
  input  logic       xferErr,
  input  logic [7:0] rdData,
  output logic       panelRst,
  output logic       busy,
  output logic       done,
  output logic       errFlag
);

  dpCmd_t dpCmd;
  logic   dlyZero, lastEntry, lastParam, hasParams;

  lcd_bringup_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .xferDone  (xferDone),
    .xferErr   (xferErr),
    .dlyZero   (dlyZero),
    .lastEntry (lastEntry),
    .lastParam (lastParam),
    .hasParams (hasParams),
    .cmd       (dpCmd),
    .xferReq   (xferReq),
    .xferRead  (xferRead),
    .panelRst  (panelRst),
    .busy      (busy),
    .done      (done),
    .errFlag   (errFlag)
  );

  lcd_bringup_dp #(
    .DLY_W        (DLY_W),
    .RST_HI_MS    (RST_HI_MS),
    .RST_LO_MS    (RST_LO_MS),
    .RST_WAIT_MS  (RST_WAIT_MS),
    .DISP_WAIT_MS (DISP_WAIT_MS),
    .ID_MATCH     (ID_MATCH)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .msTick    (msTick),
    .cmd       (dpCmd),
    .rdData    (rdData),
    .dlyZero   (dlyZero),
    .lastEntry (lastEntry),
    .lastParam (lastParam),
    .hasParams (hasParams),
    .xferWord  (xferWord)
  );

  // R12: request held with stable word until completion
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    xferReq && !xferDone |=> xferReq && $stable(xferWord) && $stable(xferRead));

endmodule

// File: tb/lcd_bringup_seq_tb.sv
module lcd_bringup_seq_tb_top;

  logic       clk = 1'b0;
  logic       rstN, msTick, start, xferDone, xferErr;
  logic [7:0] rdData;
  logic       xferReq, xferRead, panelRst, busy, done, errFlag;
  logic [8:0] xferWord;

  lcd_bringup_seq dut_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .start(start),
    .xferReq(xferReq), .xferRead(xferRead), .xferWord(xferWord),
    .xferDone(xferDone), .xferErr(xferErr), .rdData(rdData),
    .panelRst(panelRst), .busy(busy), .done(done), .errFlag(errFlag)
  );

  initial forever #4 clk = ~clk;

  typedef struct packed {
    logic [7:0] id;
    logic       idFail;
    logic [7:0] errAt;     // write index to fail, 8'hFF = none
    logic       midStart;
    logic [1:0] tbl;       // 0 = A, 1 = B, 2 = abort
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{id: 8'h80, idFail: 1'b0, errAt: 8'hFF, midStart: 1'b0, tbl: 2'd0},
    '{id: 8'h81, idFail: 1'b0, errAt: 8'hFF, midStart: 1'b0, tbl: 2'd1},
    '{id: 8'h00, idFail: 1'b0, errAt: 8'hFF, midStart: 1'b1, tbl: 2'd1},
    '{id: 8'h80, idFail: 1'b0, errAt: 8'd4,  midStart: 1'b0, tbl: 2'd0},
    '{id: 8'h80, idFail: 1'b1, errAt: 8'hFF, midStart: 1'b0, tbl: 2'd2},
    '{id: 8'h80, idFail: 1'b0, errAt: 8'hFF, midStart: 1'b0, tbl: 2'd0}
  };

  localparam int LEN_A = 11;
  localparam int LEN_B = 9;
  localparam logic [8:0] EXP_A [LEN_A] = '{9'h036, 9'h108, 9'h03A, 9'h166, 9'h0E1,
    9'h11F, 9'h120, 9'h0B4, 9'h102, 9'h029, 9'h011};
  localparam int GAP_A [LEN_A] = '{0, 0, -1, 0, -1, 0, 0, 20, 0, 100, 100};
  localparam logic [8:0] EXP_B [LEN_B] = '{9'h0BA, 9'h160, 9'h013, 9'h0B1, 9'h100,
    9'h113, 9'h113, 9'h029, 9'h011};
  localparam int GAP_B [LEN_B] = '{0, 0, -1, -1, 0, 0, 0, 3, 100};

  int   nChecks = 0, nFails = 0;
  vec_t cur;
  logic [8:0] capWord [32];
  logic       capRead [32];
  int   capGapT [32], capGapC [32];
  int   nCap, idleT, idleC, hiT, loT, postT;
  logic seenReq, sawLow;

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  // millisecond strobe, one pulse every 5 cycles
  initial begin
    msTick = 1'b0;
    forever begin
      repeat (4) @(negedge clk);
      msTick = 1'b1;
      @(negedge clk);
      msTick = 1'b0;
    end
  end

  // gap and reset-phase monitor
  initial begin
    forever begin
      @(negedge clk);
      if (busy && !xferReq) begin
        if (!seenReq) begin
          if (msTick) begin
            if (!panelRst) begin loT++; sawLow = 1'b1; end
            else if (!sawLow) hiT++;
            else postT++;
          end
        end else begin
          idleC++;
          if (msTick) idleT++;
        end
      end
    end
  end

  // serial engine model
  initial begin
    xferDone = 1'b0; xferErr = 1'b0; rdData = 8'h00;
    forever begin
      @(negedge clk);
      if (xferReq) begin
        int c;
        c = nCap;
        if (c < 32) begin
          capWord[c] = xferWord; capRead[c] = xferRead;
          capGapT[c] = idleT;    capGapC[c] = idleC;
        end
        idleT = 0; idleC = 0;
        nCap++;
        seenReq = 1'b1;
        repeat (2) @(negedge clk);
        if (xferRead) begin
          rdData  = cur.id;
          xferErr = cur.idFail;
        end else begin
          xferErr = (cur.errAt != 8'hFF) && ((c - 1) == int'(cur.errAt));
        end
        xferDone = 1'b1;
        @(negedge clk);
        xferDone = 1'b0;
        xferErr  = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    cur = VECS[0];
    nCap = 0; idleT = 0; idleC = 0; hiT = 0; loT = 0; postT = 0;
    seenReq = 1'b0; sawLow = 1'b0;
    rstN = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(!busy && !done && !errFlag && !panelRst && !xferReq, "R1", "outputs in reset",
          int'({busy, done, errFlag, panelRst, xferReq}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !errFlag && !panelRst && !xferReq, "R1", "outputs idle after reset",
          int'({busy, done, errFlag, panelRst, xferReq}), 0);

    for (int v = 0; v < NVEC; v++) begin
      int len, wordBad, roleBad, readBad, gapBad, wait_n;
      cur = VECS[v];
      nCap = 0; idleT = 0; idleC = 0; hiT = 0; loT = 0; postT = 0;
      seenReq = 1'b0; sawLow = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy && !done, "R8", "busy set, done cleared after start", int'({busy, done}), 2);
      check(!errFlag, "R10", "error flag cleared by start", int'(errFlag), 0);
      if (cur.midStart) begin
        repeat (300) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      wait_n = 0;
      while (busy && wait_n < 20000) begin
        @(negedge clk);
        wait_n++;
      end
      check(hiT == 100, "R2", "ticks with reset line high", hiT, 100);
      check(loT == 40, "R2", "ticks with reset line low", loT, 40);
      check(postT == 100, "R2", "ticks before first request", postT, 100);
      check(nCap > 0 && capRead[0], "R3", "first transfer is the id read", int'(capRead[0]), 1);

      if (cur.tbl == 2'd2) begin
        repeat (50) @(negedge clk);
        check(nCap == 1, "R9", "transfers after failed id read", nCap, 1);
        check(!busy && errFlag && !done, "R9", "status after abort",
              int'({busy, errFlag, done}), 2);
      end else begin
        len = (cur.tbl == 2'd0) ? LEN_A : LEN_B;
        wordBad = 0; roleBad = 0; readBad = 0; gapBad = 0;
        check(nCap == len + 1, "R4", "number of transfers", nCap, len + 1);
        for (int i = 0; i < len && i + 1 < 32; i++) begin
          logic [8:0] e;
          int g;
          e = (cur.tbl == 2'd0) ? EXP_A[i] : EXP_B[i];
          g = (cur.tbl == 2'd0) ? GAP_A[i] : GAP_B[i];
          if (capWord[i+1] != e) wordBad++;
          if (capWord[i+1][8] != e[8]) roleBad++;
          if (capRead[i+1]) readBad++;
          if (g == 0 && capGapC[i+1] != 0) gapBad++;
          if (g == -1 && capGapC[i+1] != 1) gapBad++;
          if (g > 0 && capGapT[i+1] != g) gapBad++;
        end
        check(wordBad == 0, "R4", "words differing from selected table", wordBad, 0);
        check(roleBad == 0, "R5", "command/parameter flag mismatches", roleBad, 0);
        check(readBad == 0, "R3", "extra read transfers", readBad, 0);
        check(gapBad == 0, "R6", "inter-word gaps wrong", gapBad, 0);
        check(capWord[len-1] == 9'h029 && capWord[len] == 9'h011, "R7", "closing commands",
              int'(capWord[len]), 9'h011);
        check(capGapT[len] == 100, "R7", "wait between display-on and sleep-out",
              capGapT[len], 100);
        check(!busy && done, "R8", "idle and done at end", int'({busy, done}), 1);
        check(errFlag == (cur.errAt != 8'hFF), "R10", "error flag at end",
              int'(errFlag), int'(cur.errAt != 8'hFF));
        if (cur.midStart)
          check(hiT == 100 && wordBad == 0, "R11", "start while busy left sequence unchanged",
                hiT, 100);
      end
      repeat (5) @(negedge clk);
    end

    // R1: reset in the middle of a run
    cur = VECS[0];
    nCap = 0; seenReq = 1'b0; sawLow = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (200) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!busy && !done && !errFlag && !panelRst && !xferReq, "R1", "outputs after mid-run reset",
          int'({busy, done, errFlag, panelRst, xferReq}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    summary();
    $finish;
  end

endmodule